// File: doc/BRIEF.md
# Ring-Counter Successive-Approximation Controller

This block sequences an 8-bit successive-approximation conversion. A one-hot token walks through a ring of slots: a clearing slot, one slot per bit from the most significant down to the least, and a store slot. A trial register beside the ring holds the code presented to an external capacitive DAC. In every decision slot the block samples a one-bit comparator verdict and either keeps or clears the bit under test, then raises the next lower bit for the following trial.

A frame is accepted from `start` when the controller is idle or in its store slot. The first cycle of the frame drives a zero trial code and keeps `done` low. The next eight cycles run the binary search. In the store slot, the finished code sits in a separate result register and `done` is high for exactly that one cycle. The result register keeps the previous answer unchanged while a new conversion is under way. If `start` is held high, frames follow one another every ten cycles.

Top module: `sar_ring_ctrl`

## Requirements
- R1: After synchronous reset, `dac_code`, `result` and `done` are all 0 and the controller is idle until `start` is seen.
- R2: A `start` that is high at a clock edge while the controller is idle begins a frame. In the first cycle of the frame (the clearing cycle), `dac_code` is 0 and `done` is 0.
- R3: In the cycle after the clearing cycle, the trial code is midscale: only bit 7 set (8'h80).
- R4: In decision cycle k (k = 1..8), the bit under test is bit 8-k. `dac_code` holds the bits already decided above it, a 1 at the bit under test, and zeros below it. At the end of that cycle the bit is kept when `cmp_hi` is 1 and cleared when it is 0, and the next lower bit is set.
- R5: A frame lasts exactly 10 cycles. `done` is high only in the tenth (store) cycle, and only for that one cycle.
- R6: While `done` is high, `result` equals the fully decided code, including the least significant bit decided in the last decision cycle, and `dac_code` shows the same code.
- R7: `result` changes only on the edge that enters the store cycle. It holds its previous value through the clearing and decision cycles and while idle.
- R8: A `start` that arrives during the clearing cycle or a decision cycle is ignored. The bit sequence and the result of the running frame are unaffected.
- R9: When `start` is high during the store cycle, the next cycle is the clearing cycle of a new frame. A held `start` therefore gives back-to-back frames with a period of 10 cycles.
- R10: When `cmp_hi` is high exactly when the sampled input value is greater than or equal to `dac_code`, `result` equals that input value for every value from 0 to 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Conversion request, sampled when idle or in the store cycle |
| cmp_hi | input | 1 | Comparator verdict: 1 when the held input is at or above the DAC level |
| dac_code | output | 8 | Trial code for the capacitive DAC |
| result | output | 8 | Last finished conversion code |
| done | output | 1 | One-cycle strobe in the store cycle |

## Verification
The assertions rely on the comparator verdict being a settled 0 or 1 at each rising edge, derived only from the code already on `dac_code`. They also rely on `start` changing only between edges. The bench meets both conditions. It computes `cmp_hi` combinationally from a held analog value and the registered trial code, and it drives `start` and that value on falling edges. The stimulus includes a full sweep, random values from a fixed seed, pulses of `start` in the middle of a frame, and a held `start`. All of these stay within those assumptions while covering every ring slot and both comparator outcomes at every bit.

// File: rtl/sar_pkg.sv
package sar_pkg;

    // Default converter resolution.
    localparam int SAR_BITS_DEF = 8;

    // Ring slots per frame: a clearing slot, one slot per bit, and a store slot.
    function automatic int frame_slots(input int nbits);
        return nbits + 2;
    endfunction

    // Phase of a frame, for naming the ring slots.
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_CLEAR  = 2'd1,
        PH_DECIDE = 2'd2,
        PH_STORE  = 2'd3
    } sar_phase_e;

endpackage

// File: rtl/sar_token_ring.sv
module sar_token_ring #(
    parameter int N = sar_pkg::SAR_BITS_DEF
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    output logic                   accept,
    output logic                   clear_slot,
    output logic [N-1:0]           test_mask,
    output logic                   load_slot,
    output logic                   store_slot,
    output sar_pkg::sar_phase_e    phase
);
    localparam int SLOTS = sar_pkg::frame_slots(N);

    logic [SLOTS-1:0] tok_q;
    logic             idle;

    assign idle   = (tok_q == '0);
    assign accept = start && (idle || tok_q[SLOTS-1]);

    always_ff @(posedge clk) begin
        if (rst) begin
            tok_q <= '0;
        end else if (accept) begin
            tok_q <= {{(SLOTS-1){1'b0}}, 1'b1};
        end else begin
            tok_q <= {tok_q[SLOTS-2:0], 1'b0};
        end
    end

    // Slot 1 tests the MSB, slot N tests the LSB.
    for (genvar j = 0; j < N; j++) begin : g_mask
        assign test_mask[N-1-j] = tok_q[1+j];
    end

    assign clear_slot = tok_q[0];
    assign load_slot  = tok_q[N];
    assign store_slot = tok_q[SLOTS-1];

    always_comb begin
        if (idle)                phase = sar_pkg::PH_IDLE;
        else if (tok_q[0])       phase = sar_pkg::PH_CLEAR;
        else if (tok_q[SLOTS-1]) phase = sar_pkg::PH_STORE;
        else                     phase = sar_pkg::PH_DECIDE;
    end

    // R5: at most one token in the ring
    assert_ring_onehot_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(tok_q));

    // R5: the last decision slot is always followed by the store slot
    assert_last_to_store_R5: assert property (@(posedge clk) disable iff (rst)
        load_slot |=> store_slot);

    // R8: a request inside a running frame does not restart it
    assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (start && (clear_slot || (|test_mask))) |=> !clear_slot);

    // R9: a request in the store slot opens a new frame at once
    assert_store_restart_R9: assert property (@(posedge clk) disable iff (rst)
        (start && store_slot) |=> clear_slot);
endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
    parameter int N = sar_pkg::SAR_BITS_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         seed,
    input  logic [N-1:0] test_mask,
    input  logic         cmp_hi,
    output logic [N-1:0] code_q,
    output logic [N-1:0] code_d
);
    localparam logic [N-1:0] MIDSCALE = {1'b1, {(N-1){1'b0}}};

    // Extended mask: the clearing slot acts as the "bit above the MSB".
    logic [N:0] ext_mask;
    assign ext_mask = {seed, test_mask};

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_comb begin
            if (clr)                code_d[i] = 1'b0;
            else if (test_mask[i])  code_d[i] = cmp_hi;
            else if (ext_mask[i+1]) code_d[i] = 1'b1;
            else                    code_d[i] = code_q[i];
        end
        always_ff @(posedge clk) begin
            if (rst) code_q[i] <= 1'b0;
            else     code_q[i] <= code_d[i];
        end
    end

    // R2: the clearing slot presents a zero trial code
    assert_clear_zero_R2: assert property (@(posedge clk) disable iff (rst)
        seed |-> (code_q == '0));

    // R3: the first trial after the clearing slot is midscale
    assert_first_midscale_R3: assert property (@(posedge clk) disable iff (rst)
        seed |=> (code_q == MIDSCALE));

    // R4: bits below the bit under test are zero during a trial
    assert_below_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (|test_mask) |-> ((code_q & (test_mask - 1'b1)) == '0));

    // R4: the bit under test is 1 while it is being tried
    assert_trial_bit_set_R4: assert property (@(posedge clk) disable iff (rst)
        (|test_mask) |-> ((code_q & test_mask) == test_mask));
endmodule

// File: rtl/sar_result_reg.sv
module sar_result_reg #(
    parameter int N = sar_pkg::SAR_BITS_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end

    // R7: the result register holds unless the store slot is being entered
    assert_result_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(q));
endmodule

// File: rtl/sar_ring_ctrl.sv
module sar_ring_ctrl #(
    parameter int N = sar_pkg::SAR_BITS_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         cmp_hi,
    output logic [N-1:0] dac_code,
    output logic [N-1:0] result,
    output logic         done
);
    logic                accept;
    logic                clear_slot;
    logic [N-1:0]        test_mask;
    logic                load_slot;
    logic                store_slot;
    sar_pkg::sar_phase_e phase;
    logic [N-1:0]        code_q;
    logic [N-1:0]        code_d;

    sar_token_ring #(.N(N)) u_ring (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .accept     (accept),
        .clear_slot (clear_slot),
        .test_mask  (test_mask),
        .load_slot  (load_slot),
        .store_slot (store_slot),
        .phase      (phase)
    );

    sar_trial_reg #(.N(N)) u_trial (
        .clk       (clk),
        .rst       (rst),
        .clr       (accept),
        .seed      (clear_slot),
        .test_mask (test_mask),
        .cmp_hi    (cmp_hi),
        .code_q    (code_q),
        .code_d    (code_d)
    );

    sar_result_reg #(.N(N)) u_result (
        .clk  (clk),
        .rst  (rst),
        .load (load_slot),
        .d    (code_d),
        .q    (result)
    );

    assign dac_code = code_q;
    assign done     = (phase == sar_pkg::PH_STORE) && store_slot;

    // R6: in the store cycle the result matches the decided trial code
    assert_done_result_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> (result == dac_code));

    // R5: done never lasts two cycles
    assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: tb/sar_ring_ctrl_tb.sv
`timescale 1ns/1ps
module sar_ring_ctrl_tb;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic         start;
    logic         cmp_hi;
    logic [N-1:0] dac_code;
    logic [N-1:0] result;
    logic         done;
    logic [N-1:0] vin;

    int compared   = 0;
    int mismatched = 0;
    logic [N-1:0] last_res;

    always #4 clk = ~clk;

    // Ideal comparator model.
    assign cmp_hi = (vin >= dac_code);

    sar_ring_ctrl #(.N(N)) u_dut (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .cmp_hi   (cmp_hi),
        .dac_code (dac_code),
        .result   (result),
        .done     (done)
    );

    function automatic logic [N-1:0] exp_trial(input logic [N-1:0] v, input int b);
        logic [N-1:0] above;
        above = ~((N'(1) << (b + 1)) - N'(1));
        if (b == N - 1) above = '0;
        return (v & above) | (N'(1) << b);
    endfunction

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // One frame. start is raised at the current falling edge.
    task automatic run_conv(input logic [N-1:0] v, input bit mid_pulse, input bit keep_start);
        vin   = v;
        start = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R2 clear code", dac_code, '0);
        chk("R2 clear done", {7'd0, done}, '0);
        chk("R7 hold in clear", result, last_res);
        if (!keep_start) start = 1'b0;
        for (int k = 1; k <= N; k++) begin
            @(posedge clk); @(negedge clk);
            if (k == 1) chk("R3 midscale", dac_code, 8'h80);
            chk("R4 trial", dac_code, exp_trial(v, N - k));
            chk("R5 done low", {7'd0, done}, '0);
            chk("R7 hold", result, last_res);
            if (mid_pulse && !keep_start) start = (k == 3 || k == 6);
        end
        start = keep_start;
        @(posedge clk); @(negedge clk);
        chk("R5 done high", {7'd0, done}, 8'd1);
        chk("R10 result", result, v);
        chk("R6 dac in store", dac_code, v);
        last_res = v;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        int seed;
        logic [N-1:0] rv;
        seed     = 32'h5A17;
        rv       = '0;
        rst      = 1'b1;
        start    = 1'b0;
        vin      = '0;
        last_res = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 dac", dac_code, '0);
        chk("R1 result", result, '0);
        chk("R1 done", {7'd0, done}, '0);
        // Idle: nothing happens without start.
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R1 idle dac", dac_code, '0);
        chk("R1 idle done", {7'd0, done}, '0);

        // Directed corners.
        run_conv(8'h00, 1'b0, 1'b0);
        run_conv(8'hFF, 1'b0, 1'b0);
        run_conv(8'h80, 1'b0, 1'b0);
        run_conv(8'h7F, 1'b0, 1'b0);
        @(posedge clk); @(negedge clk);
        chk("R5 done one cycle", {7'd0, done}, '0);
        chk("R7 hold idle", result, 8'h7F);

        // R8: start pulses mid-frame.
        run_conv(8'hA5, 1'b1, 1'b0);
        @(posedge clk); @(negedge clk);
        chk("R8 no restart", dac_code, 8'hA5);
        chk("R8 idle done", {7'd0, done}, '0);

        // R9: start held across frames, back to back.
        run_conv(8'h3C, 1'b0, 1'b1);
        run_conv(8'hC3, 1'b0, 1'b1);
        run_conv(8'h01, 1'b0, 1'b0);

        // R10: full sweep.
        for (int v = 0; v < 256; v++) begin
            run_conv(N'(v), 1'b0, 1'b0);
            if (v % 7 == 0) begin
                @(posedge clk); @(negedge clk);
            end
        end

        // Random values from a fixed seed.
        rv = N'($urandom(seed));
        for (int i = 0; i < 60; i++) begin
            rv = N'($urandom);
            run_conv(rv, (i % 3) == 0, (i % 5) == 0);
        end
        start = 1'b0;
        @(posedge clk); @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule